// File: doc/BRIEF.md
# I2C DMA Pointer and Length Tracker

This block lives inside one bus of an I2C controller and owns the state needed for byte-at-a-time DMA between the bus engine and system memory: a 34-bit memory pointer, a working byte count and a count of bytes stored during receive. Software sets it up through a small register port. There is a legacy address register, address registers for master transmit and master receive, an address register for slave receive, and upper-address companions that supply pointer bits [33:32]. The low-word registers and the upper-address companions are separate writes.

The bus engine asks for one byte at a time with `xfer_req`. The block then issues a single one-byte request on a request/acknowledge memory port at the current pointer. When the response is clean, it advances the pointer and shrinks the working length. When the response carries an error, it leaves both alone and reports the failure. If the working length is already zero, no memory access is made and the block signals completion instead. A slave-receive start reloads the pointer and length from the slave registers and clears the stored-byte count. The upper-address path exists only when the `HAS_DMA64` parameter is set.

Top module: `dma_ptr_tracker`

## Requirements
- R1: After reset, the live address read (code 0xA), the working length read (code 0xB) and the received count read (code 0xC) all return zero.
- R2: A write to master TX address (code 0x1) replaces pointer bits [31:0] with the write data and leaves bits [33:32] unchanged. The working length becomes the TX length field plus one; that field is bits [LEN_W-1:0] of the length register at code 0x8.
- R3: A write to master RX address (code 0x2) replaces pointer bits [31:0], keeps bits [33:32], and loads the working length with the RX length field plus one; that field is bits [16+LEN_W-1:16] of code 0x8.
- R4: A write to the legacy address register (code 0x0) stores the write data ANDed with 0x3FFFFFFC as pointer bits [31:0], and leaves bits [33:32] and the working length unchanged.
- R5: With HAS_DMA64=1, a write to a master TX high (0x3), master RX high (0x4) or slave RX high (0x6) register copies data bits [1:0] into pointer bits [33:32], and reading that register returns those two bits.
- R6: An xfer_req with a nonzero length raises mem_req with mem_addr equal to the full 34-bit pointer, mem_we equal to xfer_dir (1 = store xfer_wdata to memory, 0 = fetch into xfer_rdata), and holds the request until mem_ack. A clean acknowledge increments the 34-bit pointer (carrying into bit 32) and decrements the length, and pulses xfer_ok.
- R7: An acknowledge with mem_err set leaves the pointer and the length unchanged and pulses xfer_fail.
- R8: Reading code 0xA (and code 0x0) returns the live pointer bits [31:0], including increments made by transfers.
- R9: With HAS_DMA64=0, writes to codes 0x3, 0x4, 0x6 and 0x7 are ignored, so pointer bits [33:32] change only by increment carry, and reads of those codes return 0xFFFFFFFF.
- R10: A slave_start pulse clears the received count, then loads pointer bits [31:0] from slave RX address (code 0x5) and the working length from slave RX length (code 0x9, bits [LEN_W-1:0]) plus one.
- R11: The received count rises by one for each cleanly acknowledged memory store and does not change for fetches or failed accesses.
- R12: A write to the slave TX high register (code 0x7) changes no state; with HAS_DMA64=1 it reads as zero.
- R13: An xfer_req while the working length is zero issues no memory request and pulses xfer_done on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register code for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| slave_start | input | 1 | Slave receive begins |
| xfer_req | input | 1 | One-byte transfer request |
| xfer_dir | input | 1 | 1 = store to memory, 0 = fetch from memory |
| xfer_wdata | input | 8 | Byte to store |
| xfer_rdata | output | 8 | Last fetched byte |
| xfer_ok | output | 1 | Pulse: byte transferred |
| xfer_fail | output | 1 | Pulse: memory reported an error |
| xfer_done | output | 1 | Pulse: request seen with zero length |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Memory request is a store |
| mem_addr | output | 34 | Memory byte address |
| mem_wdata | output | 8 | Memory store data |
| mem_ack | input | 1 | Memory response valid |
| mem_err | input | 1 | Memory response is an error |
| mem_rdata | input | 8 | Memory fetch data |

## Verification
The assertions run on every cycle. They check the step rules after each acknowledge: increment and decrement on a clean response, no change on an error, and a received-count rise only for stores. They also check that a pending request holds a stable address, that a zero-length request yields completion without memory traffic, and the all-ones or zero readback of the upper registers in each variant. Only the bench scenarios can show the register semantics that depend on history: the carry out of the low word into bits [33:32], the legacy mask, the length-plus-one loads, the slave-start reload order, and that upper-address writes are ignored when the option is off. The bench observes these through a second instance built without the option.

// File: rtl/dma_trk_pkg.sv
package dma_trk_pkg;
   localparam int REG_AW = 4;
   localparam logic [REG_AW-1:0] RC_LEG_ADDR = 4'h0;
   localparam logic [REG_AW-1:0] RC_MTX_ADDR = 4'h1;
   localparam logic [REG_AW-1:0] RC_MRX_ADDR = 4'h2;
   localparam logic [REG_AW-1:0] RC_MTX_HI   = 4'h3;
   localparam logic [REG_AW-1:0] RC_MRX_HI   = 4'h4;
   localparam logic [REG_AW-1:0] RC_SRX_ADDR = 4'h5;
   localparam logic [REG_AW-1:0] RC_SRX_HI   = 4'h6;
   localparam logic [REG_AW-1:0] RC_STX_HI   = 4'h7;
   localparam logic [REG_AW-1:0] RC_MLEN     = 4'h8;
   localparam logic [REG_AW-1:0] RC_SLEN     = 4'h9;
   localparam logic [REG_AW-1:0] RC_CUR_ADDR = 4'hA;
   localparam logic [REG_AW-1:0] RC_CUR_LEN  = 4'hB;
   localparam logic [REG_AW-1:0] RC_RX_STS   = 4'hC;
   localparam int RX_FIELD_LSB = 16;

   typedef enum logic {SEQ_IDLE = 1'b0, SEQ_BUSY = 1'b1} seq_state_e;
endpackage

// File: rtl/dma_trk_regs.sv
module dma_trk_regs
   import dma_trk_pkg::*;
#(
   parameter int LEN_W     = 12,
   parameter int CNT_W     = 16,
   parameter int HI_W      = 2,
   parameter bit HAS_DMA64 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              slave_start,
   input  logic [31:0]       ptr_lo,
   input  logic [LEN_W:0]    work_len,
   input  logic [CNT_W-1:0]  rx_cnt,
   output logic              ld_lo,
   output logic [31:0]       ld_lo_val,
   output logic              ld_hi,
   output logic [HI_W-1:0]   ld_hi_val,
   output logic              ld_len,
   output logic [LEN_W:0]    ld_len_val,
   output logic              clr_rx
);
   localparam logic [31:0] LEG_MASK = 32'h3FFF_FFFC;

   logic [31:0]      mtx_lo_q, mrx_lo_q, srx_lo_q;
   logic [LEN_W-1:0] mlen_tx_q, mlen_rx_q, slen_q;
   logic [HI_W-1:0]  mtx_hi_q, mrx_hi_q, srx_hi_q;
   logic [31:0]      hi_rd_mtx, hi_rd_mrx, hi_rd_srx, hi_rd_stx;

   logic wr_leg, wr_mtx, wr_mrx, wr_hi;
   assign wr_leg = reg_we && (reg_addr == RC_LEG_ADDR);
   assign wr_mtx = reg_we && (reg_addr == RC_MTX_ADDR);
   assign wr_mrx = reg_we && (reg_addr == RC_MRX_ADDR);
   assign wr_hi  = reg_we && ((reg_addr == RC_MTX_HI) || (reg_addr == RC_MRX_HI) ||
                              (reg_addr == RC_SRX_HI));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mtx_lo_q  <= '0;
         mrx_lo_q  <= '0;
         srx_lo_q  <= '0;
         mlen_tx_q <= '0;
         mlen_rx_q <= '0;
         slen_q    <= '0;
      end else if (reg_we) begin
         case (reg_addr)
            RC_MTX_ADDR: mtx_lo_q <= reg_wdata;
            RC_MRX_ADDR: mrx_lo_q <= reg_wdata;
            RC_SRX_ADDR: srx_lo_q <= reg_wdata;
            RC_MLEN: begin
               mlen_tx_q <= reg_wdata[LEN_W-1:0];
               mlen_rx_q <= reg_wdata[RX_FIELD_LSB +: LEN_W];
            end
            RC_SLEN: slen_q <= reg_wdata[LEN_W-1:0];
            default: ;
         endcase
      end
   end

   generate
      if (HAS_DMA64) begin : g_hi_on
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mtx_hi_q <= '0;
               mrx_hi_q <= '0;
               srx_hi_q <= '0;
            end else if (reg_we) begin
               if (reg_addr == RC_MTX_HI) mtx_hi_q <= reg_wdata[HI_W-1:0];
               if (reg_addr == RC_MRX_HI) mrx_hi_q <= reg_wdata[HI_W-1:0];
               if (reg_addr == RC_SRX_HI) srx_hi_q <= reg_wdata[HI_W-1:0];
            end
         end
         assign hi_rd_mtx = {{(32-HI_W){1'b0}}, mtx_hi_q};
         assign hi_rd_mrx = {{(32-HI_W){1'b0}}, mrx_hi_q};
         assign hi_rd_srx = {{(32-HI_W){1'b0}}, srx_hi_q};
         assign hi_rd_stx = '0;
         assign ld_hi     = wr_hi;
      end else begin : g_hi_off
         assign mtx_hi_q  = '0;
         assign mrx_hi_q  = '0;
         assign srx_hi_q  = '0;
         assign hi_rd_mtx = '1;
         assign hi_rd_mrx = '1;
         assign hi_rd_srx = '1;
         assign hi_rd_stx = '1;
         assign ld_hi     = 1'b0;
      end
   endgenerate

   assign ld_hi_val = reg_wdata[HI_W-1:0];

   // slave start has priority over a same-cycle register write
   always_comb begin
      ld_lo      = slave_start | wr_leg | wr_mtx | wr_mrx;
      ld_len     = slave_start | wr_mtx | wr_mrx;
      clr_rx     = slave_start;
      ld_lo_val  = reg_wdata;
      ld_len_val = {1'b0, mlen_tx_q} + 1'b1;
      if (slave_start) begin
         ld_lo_val  = srx_lo_q;
         ld_len_val = {1'b0, slen_q} + 1'b1;
      end else if (wr_leg) begin
         ld_lo_val  = reg_wdata & LEG_MASK;
      end else if (wr_mrx) begin
         ld_len_val = {1'b0, mlen_rx_q} + 1'b1;
      end
   end

   always_comb begin
      case (reg_addr)
         RC_LEG_ADDR, RC_CUR_ADDR: reg_rdata = ptr_lo;
         RC_MTX_ADDR: reg_rdata = mtx_lo_q;
         RC_MRX_ADDR: reg_rdata = mrx_lo_q;
         RC_SRX_ADDR: reg_rdata = srx_lo_q;
         RC_MTX_HI:   reg_rdata = hi_rd_mtx;
         RC_MRX_HI:   reg_rdata = hi_rd_mrx;
         RC_SRX_HI:   reg_rdata = hi_rd_srx;
         RC_STX_HI:   reg_rdata = hi_rd_stx;
         RC_MLEN: begin
            reg_rdata = '0;
            reg_rdata[LEN_W-1:0] = mlen_tx_q;
            reg_rdata[RX_FIELD_LSB +: LEN_W] = mlen_rx_q;
         end
         RC_SLEN:    reg_rdata = {{(32-LEN_W){1'b0}}, slen_q};
         RC_CUR_LEN: reg_rdata = {{(31-LEN_W){1'b0}}, work_len};
         RC_RX_STS:  reg_rdata = {{(32-CNT_W){1'b0}}, rx_cnt};
         default:    reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/dma_trk_core.sv
module dma_trk_core #(
   parameter int LEN_W = 12,
   parameter int CNT_W = 16,
   parameter int HI_W  = 2,
   localparam int PTR_W = 32 + HI_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_lo,
   input  logic [31:0]      ld_lo_val,
   input  logic             ld_hi,
   input  logic [HI_W-1:0]  ld_hi_val,
   input  logic             ld_len,
   input  logic [LEN_W:0]   ld_len_val,
   input  logic             clr_rx,
   input  logic             step,
   input  logic             step_we,
   output logic [PTR_W-1:0] ptr,
   output logic [LEN_W:0]   work_len,
   output logic [CNT_W-1:0] rx_cnt
);
   logic [PTR_W-1:0] ptr_n;

   // loads override the step on the fields they touch
   always_comb begin
      ptr_n = step ? ptr + 1'b1 : ptr;
      if (ld_lo) ptr_n[31:0] = ld_lo_val;
      if (ld_hi) ptr_n[PTR_W-1:32] = ld_hi_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr      <= '0;
         work_len <= '0;
         rx_cnt   <= '0;
      end else begin
         ptr <= ptr_n;
         if (ld_len)    work_len <= ld_len_val;
         else if (step) work_len <= work_len - 1'b1;
         if (clr_rx)               rx_cnt <= '0;
         else if (step && step_we) rx_cnt <= rx_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/dma_trk_seq.sv
module dma_trk_seq
   import dma_trk_pkg::*;
#(
   parameter int PTR_W = 34
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xfer_req,
   input  logic             xfer_dir,
   input  logic [7:0]       xfer_wdata,
   input  logic             len_zero,
   input  logic [PTR_W-1:0] ptr,
   input  logic             mem_ack,
   input  logic             mem_err,
   input  logic [7:0]       mem_rdata,
   output logic             mem_req,
   output logic             mem_we,
   output logic [PTR_W-1:0] mem_addr,
   output logic [7:0]       mem_wdata,
   output logic             step,
   output logic             xfer_done,
   output logic             xfer_ok,
   output logic             xfer_fail,
   output logic [7:0]       xfer_rdata
);
   seq_state_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SEQ_IDLE;
         mem_addr   <= '0;
         mem_we     <= 1'b0;
         mem_wdata  <= '0;
         xfer_done  <= 1'b0;
         xfer_ok    <= 1'b0;
         xfer_fail  <= 1'b0;
         xfer_rdata <= '0;
      end else begin
         xfer_done <= 1'b0;
         xfer_ok   <= 1'b0;
         xfer_fail <= 1'b0;
         case (state_q)
            SEQ_IDLE: if (xfer_req) begin
               if (len_zero) begin
                  xfer_done <= 1'b1;
               end else begin
                  state_q   <= SEQ_BUSY;
                  mem_addr  <= ptr;
                  mem_we    <= xfer_dir;
                  mem_wdata <= xfer_wdata;
               end
            end
            SEQ_BUSY: if (mem_ack) begin
               state_q <= SEQ_IDLE;
               if (mem_err) xfer_fail <= 1'b1;
               else         xfer_ok   <= 1'b1;
               if (!mem_err && !mem_we) xfer_rdata <= mem_rdata;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign mem_req = (state_q == SEQ_BUSY);
   assign step    = mem_req && mem_ack && !mem_err;
endmodule

// File: rtl/dma_ptr_tracker.sv
module dma_ptr_tracker
   import dma_trk_pkg::*;
#(
   parameter int LEN_W     = 12,
   parameter int CNT_W     = 16,
   parameter int HI_W      = 2,
   parameter bit HAS_DMA64 = 1'b1,
   localparam int PTR_W    = 32 + HI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              slave_start,
   input  logic              xfer_req,
   input  logic              xfer_dir,
   input  logic [7:0]        xfer_wdata,
   output logic [7:0]        xfer_rdata,
   output logic              xfer_ok,
   output logic              xfer_fail,
   output logic              xfer_done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [PTR_W-1:0]  mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic [7:0]        mem_rdata
);
   generate
      if (LEN_W < 1 || LEN_W > 15) begin : g_bad_len
         $error("LEN_W must lie in 1..15");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must lie in 1..32");
      end
      if (HI_W < 1 || HI_W > 32) begin : g_bad_hi
         $error("HI_W must lie in 1..32");
      end
   endgenerate

   logic [PTR_W-1:0] ptr_w;
   logic [LEN_W:0]   len_w, ld_len_val;
   logic [CNT_W-1:0] rx_w;
   logic             ld_lo, ld_hi, ld_len, clr_rx, step;
   logic [31:0]      ld_lo_val;
   logic [HI_W-1:0]  ld_hi_val;

   dma_trk_regs #(.LEN_W(LEN_W), .CNT_W(CNT_W), .HI_W(HI_W), .HAS_DMA64(HAS_DMA64)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slave_start(slave_start),
      .ptr_lo(ptr_w[31:0]), .work_len(len_w), .rx_cnt(rx_w),
      .ld_lo(ld_lo), .ld_lo_val(ld_lo_val), .ld_hi(ld_hi), .ld_hi_val(ld_hi_val),
      .ld_len(ld_len), .ld_len_val(ld_len_val), .clr_rx(clr_rx));

   dma_trk_core #(.LEN_W(LEN_W), .CNT_W(CNT_W), .HI_W(HI_W)) u_core (
      .clk(clk), .rst_n(rst_n), .ld_lo(ld_lo), .ld_lo_val(ld_lo_val),
      .ld_hi(ld_hi), .ld_hi_val(ld_hi_val), .ld_len(ld_len), .ld_len_val(ld_len_val),
      .clr_rx(clr_rx), .step(step), .step_we(mem_we),
      .ptr(ptr_w), .work_len(len_w), .rx_cnt(rx_w));

   dma_trk_seq #(.PTR_W(PTR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_dir(xfer_dir),
      .xfer_wdata(xfer_wdata), .len_zero(len_w == '0), .ptr(ptr_w),
      .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .step(step), .xfer_done(xfer_done), .xfer_ok(xfer_ok), .xfer_fail(xfer_fail),
      .xfer_rdata(xfer_rdata));
endmodule

// File: rtl/dma_ptr_tracker_chk.sv
module dma_ptr_tracker_chk
   import dma_trk_pkg::*;
#(
   parameter int LEN_W     = 12,
   parameter int CNT_W     = 16,
   parameter int PTR_W     = 34,
   parameter bit HAS_DMA64 = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic              slave_start,
   input logic [REG_AW-1:0] reg_addr,
   input logic [31:0]       reg_rdata,
   input logic              xfer_req,
   input logic              xfer_done,
   input logic              mem_req,
   input logic              mem_ack,
   input logic              mem_err,
   input logic              mem_we,
   input logic [PTR_W-1:0]  mem_addr,
   input logic [PTR_W-1:0]  ptr,
   input logic [LEN_W:0]    work_len,
   input logic [CNT_W-1:0]  rx_cnt
);
   logic quiet;
   assign quiet = !reg_we && !slave_start;

   // R13
   zero_len_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_req && xfer_req && work_len == '0) |=> (xfer_done && !mem_req));

   // R6
   step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && !mem_err && quiet) |=>
      (ptr == PTR_W'($past(ptr) + 1'b1) && work_len == (LEN_W+1)'($past(work_len) - 1'b1)));

   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   // R7
   err_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && mem_err && quiet) |=> ($stable(ptr) && $stable(work_len)));

   // R11
   rx_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && !mem_err && mem_we && quiet) |=>
      (rx_cnt == CNT_W'($past(rx_cnt) + 1'b1)));

   // R11
   rx_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(mem_req && mem_ack && !mem_err && mem_we) && quiet) |=> $stable(rx_cnt));

   generate
      if (HAS_DMA64) begin : g_on
         // R12
         stx_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_addr == RC_STX_HI) |-> (reg_rdata == '0));
      end else begin : g_off
         // R9
         hi_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_addr == RC_MTX_HI || reg_addr == RC_MRX_HI ||
             reg_addr == RC_SRX_HI || reg_addr == RC_STX_HI) |-> (reg_rdata == '1));
      end
   endgenerate
endmodule

bind dma_ptr_tracker dma_ptr_tracker_chk #(
   .LEN_W(LEN_W), .CNT_W(CNT_W), .PTR_W(PTR_W), .HAS_DMA64(HAS_DMA64)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .slave_start(slave_start),
   .reg_addr(reg_addr), .reg_rdata(reg_rdata), .xfer_req(xfer_req),
   .xfer_done(xfer_done), .mem_req(mem_req), .mem_ack(mem_ack), .mem_err(mem_err),
   .mem_we(mem_we), .mem_addr(mem_addr), .ptr(ptr_w), .work_len(len_w), .rx_cnt(rx_w)
);

// File: tb/sim_dma_ptr_tracker.sv
`timescale 1ns/1ps
module sim_dma_ptr_tracker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        slave_start = 1'b0;
   logic        xfer_req = 1'b0;
   logic        xfer_dir = 1'b0;
   logic [7:0]  xfer_wdata = '0;
   logic        mem_ack = 1'b0;
   logic        mem_err = 1'b0;
   logic [7:0]  mem_rdata = '0;

   logic [31:0] rd0, rd1;
   logic [7:0]  xr0, xr1, mwd0, mwd1;
   logic        ok0, ok1, fl0, fl1, dn0, dn1, mq0, mq1, mw0, mw1;
   logic [33:0] ma0, ma1;

   always #4 clk = ~clk;

   dma_ptr_tracker #(.HAS_DMA64(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(rd0), .slave_start(slave_start), .xfer_req(xfer_req), .xfer_dir(xfer_dir),
      .xfer_wdata(xfer_wdata), .xfer_rdata(xr0), .xfer_ok(ok0), .xfer_fail(fl0),
      .xfer_done(dn0), .mem_req(mq0), .mem_we(mw0), .mem_addr(ma0), .mem_wdata(mwd0),
      .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata));

   dma_ptr_tracker #(.HAS_DMA64(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(rd1), .slave_start(slave_start), .xfer_req(xfer_req), .xfer_dir(xfer_dir),
      .xfer_wdata(xfer_wdata), .xfer_rdata(xr1), .xfer_ok(ok1), .xfer_fail(fl1),
      .xfer_done(dn1), .mem_req(mq1), .mem_we(mw1), .mem_addr(ma1), .mem_wdata(mwd1),
      .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata));

   // behavioural reference state
   longint unsigned m_ptr0, m_ptr1;
   int m_len, m_rx, m_mtx, m_mrx, m_slen;
   longint unsigned m_srx;
   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;
   localparam longint unsigned PMASK = 64'h3_FFFF_FFFF;

   task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic set_lo(input longint unsigned v);
      m_ptr0 = (m_ptr0 & 64'h3_0000_0000) | (v & 64'hFFFF_FFFF);
      m_ptr1 = (m_ptr1 & 64'h3_0000_0000) | (v & 64'hFFFF_FFFF);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      case (a)
         4'h0: set_lo(d & 32'h3FFF_FFFC);
         4'h1: begin set_lo(d); m_len = m_mtx + 1; end
         4'h2: begin set_lo(d); m_len = m_mrx + 1; end
         4'h3, 4'h4, 4'h6: m_ptr0 = (m_ptr0 & 64'hFFFF_FFFF) | (longint'(d[1:0]) << 32);
         4'h5: m_srx = d;
         4'h8: begin m_mtx = int'(d[11:0]); m_mrx = int'(d[27:16]); end
         4'h9: m_slen = int'(d[11:0]);
         default: ;
      endcase
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] r0, output logic [31:0] r1);
      @(negedge clk);
      reg_addr = a;
      #1;
      r0 = rd0; r1 = rd1;
   endtask

   task automatic check_state(input string req);
      logic [31:0] a0, a1;
      rd(4'hA, a0, a1);
      check({req, " live addr u0"}, a0, m_ptr0 & 64'hFFFF_FFFF);
      check({req, " live addr u1"}, a1, m_ptr1 & 64'hFFFF_FFFF);
      rd(4'hB, a0, a1);
      check({req, " length"}, a0, longint'(m_len));
      rd(4'hC, a0, a1);
      check({req, " rx count"}, a0, longint'(m_rx));
   endtask

   task automatic xfer(input string req, input logic dir, input logic [7:0] wb,
                       input logic err, input logic [7:0] rb);
      @(negedge clk);
      xfer_req = 1'b1; xfer_dir = dir; xfer_wdata = wb;
      @(negedge clk);
      xfer_req = 1'b0;
      if (m_len == 0) begin
         check({req, " done pulse"}, dn0, 1);
         check({req, " no mem_req"}, mq0, 0);
         @(negedge clk);
         check({req, " done cleared, still idle"}, {dn0, mq0}, 0);
         return;
      end
      check({req, " mem_req"}, mq0, 1);
      check({req, " mem_addr u0"}, ma0, m_ptr0);
      check({req, " mem_addr u1"}, ma1, m_ptr1);
      check({req, " mem_we"}, mw0, dir);
      if (dir) check({req, " mem_wdata"}, mwd0, wb);
      @(negedge clk);
      check({req, " request held"}, mq0, 1);
      mem_ack = 1'b1; mem_err = err; mem_rdata = rb;
      @(negedge clk);
      mem_ack = 1'b0; mem_err = 1'b0;
      check({req, " ok pulse"}, ok0, !err);
      check({req, " fail pulse"}, fl0, err);
      check({req, " request dropped"}, mq0, 0);
      if (!dir && !err) check({req, " fetched byte"}, xr0, rb);
      if (!err) begin
         m_ptr0 = (m_ptr0 + 1) & PMASK;
         m_ptr1 = (m_ptr1 + 1) & PMASK;
         m_len  = m_len - 1;
         if (dir) m_rx = m_rx + 1;
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] a0, a1;
      m_ptr0 = 0; m_ptr1 = 0; m_len = 0; m_rx = 0;
      m_mtx = 0; m_mrx = 0; m_slen = 0; m_srx = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check_state("R1");

      // R5 / R9 high registers
      wr(4'h8, 32'h0005_0003);
      wr(4'h3, 32'h0000_0002);
      rd(4'h3, a0, a1);
      check("R5 MTX high readback u0", a0, 2);
      check("R9 MTX high reads ones u1", a1, 32'hFFFF_FFFF);
      rd(4'h7, a0, a1);
      check("R12 STX high reads zero u0", a0, 0);
      check("R9 STX high reads ones u1", a1, 32'hFFFF_FFFF);

      // R2 master TX load, R8 live read
      wr(4'h1, 32'hFFFF_FFFE);
      check_state("R2");

      // R6 fetches crossing into bit 32, R8 live pointer
      xfer("R6 fetch a", 1'b0, 8'h00, 1'b0, 8'hA5);
      xfer("R6 fetch b carry", 1'b0, 8'h00, 1'b0, 8'h5A);
      check_state("R8");

      // R7 error leaves state
      xfer("R7 error", 1'b1, 8'h77, 1'b1, 8'h00);
      check_state("R7");

      // R11 store counts, fetch does not
      xfer("R11 store", 1'b1, 8'h3C, 1'b0, 8'h00);
      xfer("R11 fetch", 1'b0, 8'h00, 1'b0, 8'hC3);
      check_state("R11");

      // R13 zero length
      xfer("R13 zero length", 1'b1, 8'h11, 1'b0, 8'h00);
      check_state("R13");

      // R4 legacy mask
      wr(4'h0, 32'hFFFF_FFFF);
      check_state("R4");

      // R5 / R9 / R12 high paths, R3 master RX load
      wr(4'h4, 32'hFFFF_FFF1);
      wr(4'h7, 32'h0000_0002);
      wr(4'h2, 32'h0000_1000);
      check_state("R3");
      xfer("R5 R12 high bits", 1'b0, 8'h00, 1'b0, 8'h99);

      // R10 slave receive start
      wr(4'h5, 32'h0000_2000);
      wr(4'h9, 32'h0000_0001);
      wr(4'h6, 32'h0000_0000);
      @(negedge clk); slave_start = 1'b1;
      @(negedge clk); slave_start = 1'b0;
      m_rx = 0; set_lo(m_srx); m_len = m_slen + 1;
      check_state("R10");
      xfer("R10 slave store a", 1'b1, 8'hE1, 1'b0, 8'h00);
      xfer("R10 slave store b", 1'b1, 8'hE2, 1'b0, 8'h00);
      check_state("R10 R11 after stores");
      xfer("R13 slave exhausted", 1'b1, 8'hE3, 1'b0, 8'h00);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule